// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address for each beat of a four-beat burst into a synchronous memory. When an access starts, it captures the whole external address. Either of two active-low address strobes starts an access, but only while the load-enable input is high. After that, each active-low advance moves the two low address bits one step through the chosen burst order. The upper bits stay fixed.

Two orders are available. The interleaved order is the start value XOR a beat count. The linear order is the start value plus the beat count. Both wrap modulo four. The order is taken from the mode input at the moment of the load and is then held for the rest of the burst. The output address comes straight from registered state, so it is valid in the cycle after the edge that loaded or advanced it.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the output address to zero, with the beat count at zero and linear order selected.
- R2: A start captures addr_in, and the output equals that address after the edge. A start is load_en high with at least one strobe low at a rising edge.
- R3: While load_en is low, both strobes are ignored and the output keeps following the current burst.
- R4: adv_n is ignored in a start cycle: the first output after a load is always the loaded address.
- R5: With no start and adv_n high, the output address holds its value.
- R6: With mode_ilv low at the load (linear order), each advance adds one to addr_out[1:0] modulo 4.
- R7: With mode_ilv high at the load (interleaved order), the low bits are start XOR beat. From a start of 01, this gives 01, 00, 11, 10.
- R8: mode_ilv is sampled only at a load. Changing it during a burst leaves the order unchanged.
- R9: The fourth advance after a load returns the low bits to the start value.
- R10: Between loads, addr_out[16:2] stays equal to the loaded address bits.
- R11: Each strobe starts an access on its own: strb_a_n alone does, and strb_b_n alone does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | 17 | External address |
| strb_a_n | input | 1 | First start strobe, active low |
| strb_b_n | input | 1 | Second start strobe, active low |
| load_en | input | 1 | Qualifies both strobes (select decode) |
| adv_n | input | 1 | Advance to next beat, active low |
| mode_ilv | input | 1 | Burst order at load: 1 interleaved, 0 linear |
| addr_out | output | 17 | Current memory address |

## Verification
The assertions assume reset is held from time zero through the first edge. They also assume every input is at a known level at each rising edge, because the start decode and the advance path have no defined value under an X. The stimulus meets both assumptions. It holds reset from time zero and only changes inputs on the falling edge, so every input is settled well before the next rising edge. It then runs directed bursts in both orders, followed by a long random stretch with every input a defined bit.

// File: rtl/burst_pkg.sv
package burst_pkg;
    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_ILV    = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_start_detect.sv
module burst_start_detect (
    input  logic load_en,
    input  logic strb_a_n,
    input  logic strb_b_n,
    output logic start
);
    // Either strobe may open an access, qualified by the select decode
    always_comb begin
        start = load_en && (!strb_a_n || !strb_b_n);
    end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
#(
    parameter int BEAT_W = 2
) (
    input  logic [BEAT_W-1:0] seed,
    input  logic [BEAT_W-1:0] beat,
    input  burst_order_e      order,
    output logic [BEAT_W-1:0] low
);
    logic [BEAT_W-1:0] low_ilv;
    logic [BEAT_W-1:0] low_lin;

    always_comb begin
        low_ilv = seed ^ beat;
        low_lin = seed + beat;
        low     = (order == ORDER_ILV) ? low_ilv : low_lin;
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              strb_a_n,
    input  logic              strb_b_n,
    input  logic              load_en,
    input  logic              adv_n,
    input  logic              mode_ilv,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;
    localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [BEAT_W-1:0] beat;
        burst_order_e      order;
    } state_t;

    state_t st_d, st_q;
    logic   start;
    logic [BEAT_W-1:0] low;

    burst_start_detect u_start (
        .load_en  (load_en),
        .strb_a_n (strb_a_n),
        .strb_b_n (strb_b_n),
        .start    (start)
    );

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.base  = addr_in;
            st_d.beat  = '0;
            st_d.order = burst_order_e'(mode_ilv);
        end else if (!adv_n) begin
            st_d.beat = st_q.beat + BEAT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    burst_order_map #(.BEAT_W(BEAT_W)) u_map (
        .seed  (st_q.base[BEAT_W-1:0]),
        .beat  (st_q.beat),
        .order (st_q.order),
        .low   (low)
    );

    assign addr_out = {st_q.base[ADDR_W-1:BEAT_W], low};

    // R2 R4
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> addr_out == $past(addr_in));

    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && adv_n) |=> $stable(addr_out));

    // R10
    upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W]));

    // R6
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !adv_n && st_q.order == ORDER_LINEAR)
        |=> addr_out[BEAT_W-1:0] == $past(addr_out[BEAT_W-1:0]) + BEAT_ONE);

    // R7
    ilv_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !adv_n && st_q.order == ORDER_ILV)
        |=> (addr_out[BEAT_W-1:0] ^ $past(addr_out[BEAT_W-1:0]))
            == ($past(st_q.beat) ^ ($past(st_q.beat) + BEAT_ONE)));

    // R8
    order_kept_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(st_q.order));

    // R1
    always_ff @(posedge clk) begin
        if ($past(rst) === 1'b1) begin
            reset_zero_chk: assert (addr_out == '0);
        end
    end

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr_out[ADDR_W-1:BEAT_W];
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] addr_in = '0;
    logic        strb_a_n = 1'b1;
    logic        strb_b_n = 1'b1;
    logic        load_en = 1'b0;
    logic        adv_n = 1'b1;
    logic        mode_ilv = 1'b0;
    logic [16:0] addr_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int m_base = 0;
    int m_beat = 0;
    int m_ilv  = 0;

    always #2.5 clk = ~clk;

    burst_addr_gen u_dut (
        .clk(clk), .rst(rst), .addr_in(addr_in),
        .strb_a_n(strb_a_n), .strb_b_n(strb_b_n), .load_en(load_en),
        .adv_n(adv_n), .mode_ilv(mode_ilv), .addr_out(addr_out)
    );

    function automatic int model_addr();
        int lo;
        if (m_ilv != 0) lo = (m_base % 4) ^ m_beat;
        else            lo = ((m_base % 4) + m_beat) % 4;
        return (m_base - (m_base % 4)) + lo;
    endfunction

    task automatic check(input string tag, input int exp);
        n_chk++;
        if (int'(addr_out) != exp) begin
            n_bad++;
            $display("FAIL %s: addr_out actual %05h expected %05h", tag, addr_out, exp[16:0]);
        end
    endtask

    // one clock: apply inputs, update model on the edge, compare at the falling edge
    task automatic cyc(input string tag, input bit r, input int a, input bit sa_n,
                       input bit sb_n, input bit le, input bit av_n, input bit md);
        rst = r; addr_in = a[16:0]; strb_a_n = sa_n; strb_b_n = sb_n;
        load_en = le; adv_n = av_n; mode_ilv = md;
        @(posedge clk);
        if (r) begin
            m_base = 0; m_beat = 0; m_ilv = 0;
        end else if (le && (!sa_n || !sb_n)) begin
            m_base = a & 17'h1FFFF; m_beat = 0; m_ilv = md;
        end else if (!av_n) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag, model_addr());
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ilv_seq[4] = '{1, 0, 3, 2};
        @(negedge clk);
        // R1
        cyc("R1 reset", 1, 17'h1FFFF, 0, 0, 1, 0, 1);
        cyc("R1 reset", 1, 0, 1, 1, 0, 1, 0);
        check("R1 zero", 0);
        // R2 R11: strobe A alone, linear
        cyc("R2 R11 load A", 0, 17'h1ABCE, 0, 1, 1, 1, 0);
        check("R2 captured", 17'h1ABCE);
        // R6 R9 R10
        for (int i = 1; i <= 4; i++) begin
            cyc("R6 linear adv", 0, 0, 1, 1, 1, 0, 1);
            check("R6 R10 linear", 17'h1ABCC | ((2 + i) % 4));
        end
        check("R9 wrap", 17'h1ABCE);
        // R5
        cyc("R5 hold", 0, 17'h00001, 1, 1, 1, 1, 1);
        cyc("R5 hold", 0, 17'h00002, 1, 1, 0, 1, 0);
        check("R5 held", 17'h1ABCE);
        // R4 R11: strobe B alone, advance asserted in load cycle, interleaved
        cyc("R4 R11 load B", 0, 17'h05551, 1, 0, 1, 0, 1);
        check("R4 first beat", 17'h05551);
        // R7 R8: mode flips mid-burst
        for (int i = 1; i <= 3; i++) begin
            cyc("R7 R8 ilv adv", 0, 0, 1, 1, 1, 0, i[0]);
            check("R7 R8 ilv order", 17'h05550 | ilv_seq[i]);
        end
        cyc("R9 ilv wrap", 0, 0, 1, 1, 1, 0, 0);
        check("R9 ilv wrap", 17'h05551);
        // R3: strobes without load_en
        cyc("R3 ignored", 0, 17'h0FFFF, 0, 0, 0, 1, 0);
        check("R3 unchanged", 17'h05551);
        cyc("R3 ignored adv", 0, 17'h0FFFF, 0, 1, 0, 0, 0);
        check("R3 follows burst", 17'h05550);
        // random stretch against the model
        for (int i = 0; i < 2000; i++) begin
            int r = $urandom;
            cyc("R2 R3 R5 R6 R7 R8 random", (r[7:0] == 0), $urandom,
                r[8] | r[9], r[10] | r[11], r[12] | r[13], r[14] & r[15] ? 1'b1 : r[16], r[17]);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule